// File: doc/BRIEF.md
# TDM Frame Sync Delay Aligner

This block locates the first bit of each frame on a serial time-division-multiplexed line. Bit clock, frame sync and receive data come in as plain input levels. The block samples them with its own system clock and turns the bit clock transitions into one-cycle edge events. A frame sync becomes valid on a chosen bit-clock edge. After a programmed number of data edges (0 to 3), the block presents bit 0 of the frame. It then steps a bit index on every data edge until the configured frame length is reached, and waits for the next sync.

For each frame bit, the block drives the transmit line from a parallel frame word. It also captures the receive line into a parallel frame register. A start-of-frame strobe marks bit 0. A sync that arrives while a frame is still pending or running restarts the alignment and raises a one-cycle error pulse.

A D-channel grant is kept in a register. It is loaded in one of two ways, chosen by a mode input:
- sampled from a grant input while sync is high, with an enable gate, or
- copied from the receive bit of any slot whose channel-select input carries the mark code.

The controller is a three-state machine:
- **IDLE**: waits for sync. `start` (sync with delay 0 on a coinciding data edge) goes to ACTIVE. `arm` (any other sync) goes to DELAY.
- **DELAY**: counts data edges. `expire` (counter at zero on a data edge) goes to ACTIVE and presents bit 0. `resync` (sync) reloads the counter and stays in, or returns to, DELAY.
- **ACTIVE**: steps the bit index. `advance` moves to the next bit. `finish` (data edge after the last bit) goes to IDLE. `resync` goes to DELAY, or restarts at bit 0 when the delay is 0.

Top module: `tdm_sync_aligner`

## Requirements
- R1: After reset, `frame_act`, `sof`, `txd`, `resync_err`, `grant`, `bit_idx` and `rx_frame` are all zero.
- R2: `cfg_delay` values 0, 1, 2 and 3 place bit 0 on that many data edges after the edge that latched sync, when sync and data use the same edge. With value 0, bit 0 is presented on the latching edge itself.
- R3: `cfg_data_edge` = 0 moves data on bclk rising edges. `cfg_data_edge` = 1 moves data on falling edges.
- R4: `cfg_sync_edge` = 0 samples fsync on rising edges and 1 samples it on falling edges. A sync is taken when fsync is sampled high after being sampled low on the previous sync edge. If no data edge coincides with that sync edge, the next data edge counts as edge 0 of the delay.
- R5: In a frame, `bit_idx` runs 0, 1, … `cfg_frame_len`−1, one step per data edge, with `frame_act` high. On the data edge after the last bit, `frame_act` falls and stays low until a new sync.
- R6: `sof` is high for exactly one bit period: while bit 0 is presented.
- R7: While `frame_act` is high, `txd` equals `tx_frame[bit_idx]`. While it is low, `txd` is 0.
- R8: On the data edge that presents bit k, the sampled `rxd` is stored in `rx_frame[k]`. The other bits of `rx_frame` keep their value.
- R9: A sync taken while in DELAY, or in ACTIVE other than on the edge that finishes the last bit, restarts the delay and bit count. It also pulses `resync_err` for one system clock.
- R10: A sync that coincides with the data edge finishing the last bit starts the next frame without an error pulse.
- R11: With `cfg_grant_mode` = 1, on each sync edge where fsync is high, `grant` is loaded with `grant_in` AND `cfg_grant_en`.
- R12: With `cfg_grant_mode` = 0, on a frame bit whose `chan_sel` is 4'b0111, `grant` is loaded with that bit's `rxd`. Any other `chan_sel` value leaves `grant` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than bclk |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Serial bit clock level |
| fsync | input | 1 | Frame sync level |
| rxd | input | 1 | Serial receive data |
| chan_sel | input | 4 | Channel-select code for the current bit (4'b0111 marks the grant bit) |
| grant_in | input | 1 | External grant level |
| cfg_delay | input | 2 | Sync-to-first-bit delay in data edges |
| cfg_data_edge | input | 1 | 0 rising, 1 falling edge for data |
| cfg_sync_edge | input | 1 | 0 rising, 1 falling edge for sync |
| cfg_frame_len | input | IDX_W+1 | Frame length in bits, 1 to FRAME_MAX |
| cfg_grant_mode | input | 1 | 1 sample grant_in during sync, 0 marked receive bit |
| cfg_grant_en | input | 1 | Gate for grant mode 1 |
| tx_frame | input | FRAME_MAX | Parallel transmit frame, bit k sent as frame bit k |
| txd | output | 1 | Serial transmit data |
| rx_frame | output | FRAME_MAX | Captured receive frame |
| bit_idx | output | IDX_W | Index of the bit being presented |
| sof | output | 1 | Start-of-frame strobe |
| frame_act | output | 1 | High while frame bits are presented |
| resync_err | output | 1 | One-cycle pulse on a mid-frame sync |
| grant | output | 1 | D-channel grant |

## Verification
The bench builds the block with FRAME_MAX = 16, so IDX_W = 4. The bit clock is generated as eight system clocks per bit, with inputs changed mid-phase. This makes every edge event and every output update land at a known phase.

Frames of 4, 6 and 8 bits keep each scenario short, and still reach:
- all four delay codes,
- all combinations of sync edge and data edge,
- a frame end followed by idle,
- a back-to-back sync on the finishing edge,
- a mid-frame restart,
- both grant modes, including the enable gate and unmarked slots.

// File: rtl/tdm_aln_pkg.sv
package tdm_aln_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DELAY  = 2'd1,
        ST_ACTIVE = 2'd2
    } aln_state_e;

    localparam logic [3:0] GRANT_MARK = 4'b0111;

endpackage

// File: rtl/tdm_aln_insync.sv
module tdm_aln_insync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/tdm_aln_edges.sv
module tdm_aln_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_s,
    input  logic fsync_s,
    input  logic data_fall,
    input  logic sync_fall,
    output logic d_ev,
    output logic s_ev,
    output logic sync_hit
);

    logic bclk_d;
    logic fs_lat;
    logic rise_ev;
    logic fall_ev;

    assign rise_ev  = bclk_s & ~bclk_d;
    assign fall_ev  = ~bclk_s & bclk_d;
    assign d_ev     = data_fall ? fall_ev : rise_ev;
    assign s_ev     = sync_fall ? fall_ev : rise_ev;
    assign sync_hit = s_ev & fsync_s & ~fs_lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_d <= 1'b0;
            fs_lat <= 1'b0;
        end else begin
            bclk_d <= bclk_s;
            if (s_ev) begin
                fs_lat <= fsync_s;
            end
        end
    end

endmodule

// File: rtl/tdm_aln_fsm.sv
module tdm_aln_fsm
    import tdm_aln_pkg::*;
#(
    parameter  int FRAME_MAX = 32,
    localparam int IDX_W     = $clog2(FRAME_MAX),
    localparam int LEN_W     = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 d_ev,
    input  logic                 sync_hit,
    input  logic                 rxd_s,
    input  logic [1:0]           cfg_delay,
    input  logic [LEN_W-1:0]     cfg_frame_len,
    input  logic [FRAME_MAX-1:0] tx_frame,
    output logic [IDX_W-1:0]     bit_idx,
    output logic                 frame_act,
    output logic                 sof,
    output logic                 txd,
    output logic [FRAME_MAX-1:0] rx_frame,
    output logic                 resync_err,
    output logic                 slot_ev
);

    aln_state_e       st, nxt;
    logic [1:0]       rem, rem_n;
    logic [IDX_W-1:0] idx, idx_n;
    logic [LEN_W-1:0] len_m1;
    logic             last_bit;
    logic             finishing;
    logic             err_n;

    assign len_m1    = cfg_frame_len - LEN_W'(1);
    assign last_bit  = ({1'b0, idx} == len_m1);
    assign finishing = (st == ST_ACTIVE) && d_ev && last_bit;
    assign bit_idx   = idx;
    assign frame_act = (st == ST_ACTIVE);

    // next-state and counter decisions
    always_comb begin
        nxt     = st;
        rem_n   = rem;
        idx_n   = idx;
        slot_ev = 1'b0;
        err_n   = 1'b0;
        if (sync_hit) begin
            err_n = (st == ST_DELAY) || ((st == ST_ACTIVE) && !finishing);
            if (d_ev && (cfg_delay == 2'd0)) begin
                nxt     = ST_ACTIVE;
                idx_n   = '0;
                slot_ev = 1'b1;
            end else begin
                nxt   = ST_DELAY;
                rem_n = d_ev ? (cfg_delay - 2'd1) : cfg_delay;
            end
        end else if (d_ev) begin
            unique case (st)
                ST_IDLE: nxt = ST_IDLE;
                ST_DELAY: begin
                    if (rem == 2'd0) begin
                        nxt     = ST_ACTIVE;
                        idx_n   = '0;
                        slot_ev = 1'b1;
                    end else begin
                        rem_n = rem - 2'd1;
                    end
                end
                ST_ACTIVE: begin
                    if (last_bit) begin
                        nxt = ST_IDLE;
                    end else begin
                        idx_n   = idx + 1'b1;
                        slot_ev = 1'b1;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            rem <= 2'd0;
            idx <= '0;
        end else begin
            st  <= nxt;
            rem <= rem_n;
            idx <= idx_n;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sof        <= 1'b0;
            txd        <= 1'b0;
            rx_frame   <= '0;
            resync_err <= 1'b0;
        end else begin
            resync_err <= err_n;
            if (sync_hit || d_ev) begin
                sof <= slot_ev && (idx_n == '0);
                txd <= (nxt == ST_ACTIVE) ? tx_frame[idx_n] : 1'b0;
            end
            if (slot_ev) begin
                rx_frame[idx_n] <= rxd_s;
            end
        end
    end

    p_sof_bit0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> (frame_act && (bit_idx == '0)))
        else $error("sof outside bit 0");

    p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_act |-> ({1'b0, bit_idx} < cfg_frame_len))
        else $error("bit index beyond frame length");

    p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_act && $past(frame_act) && !sof && (bit_idx != $past(bit_idx)))
            |-> (bit_idx == $past(bit_idx) + 1'b1))
        else $error("bit index skipped");

    p_txd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_act |-> !txd)
        else $error("txd active outside frame");

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resync_err |=> !resync_err)
        else $error("resync error longer than one cycle");

endmodule

// File: rtl/tdm_aln_grant.sv
module tdm_aln_grant
    import tdm_aln_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_sync,
    input  logic       grant_en,
    input  logic       s_ev,
    input  logic       fsync_s,
    input  logic       slot_ev,
    input  logic [3:0] chan_sel_s,
    input  logic       rxd_s,
    input  logic       grant_s,
    output logic       grant
);

    logic sync_samp;
    logic mark_samp;

    assign sync_samp = mode_sync && s_ev && fsync_s;
    assign mark_samp = !mode_sync && slot_ev && (chan_sel_s == GRANT_MARK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant <= 1'b0;
        end else if (sync_samp) begin
            grant <= grant_s & grant_en;
        end else if (mark_samp) begin
            grant <= rxd_s;
        end
    end

    p_gnt_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_samp) && !$past(grant_en)) |-> !grant)
        else $error("grant loaded while disabled");

    p_gnt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sync && !$past(mode_sync) && !$past(mark_samp)) |-> $stable(grant))
        else $error("grant changed on unmarked slot");

endmodule

// File: rtl/tdm_sync_aligner.sv
module tdm_sync_aligner
    import tdm_aln_pkg::*;
#(
    parameter  int FRAME_MAX = 32,
    localparam int IDX_W     = $clog2(FRAME_MAX)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bclk,
    input  logic                 fsync,
    input  logic                 rxd,
    input  logic [3:0]           chan_sel,
    input  logic                 grant_in,
    input  logic [1:0]           cfg_delay,
    input  logic                 cfg_data_edge,
    input  logic                 cfg_sync_edge,
    input  logic [IDX_W:0]       cfg_frame_len,
    input  logic                 cfg_grant_mode,
    input  logic                 cfg_grant_en,
    input  logic [FRAME_MAX-1:0] tx_frame,
    output logic                 txd,
    output logic [FRAME_MAX-1:0] rx_frame,
    output logic [IDX_W-1:0]     bit_idx,
    output logic                 sof,
    output logic                 frame_act,
    output logic                 resync_err,
    output logic                 grant
);

    localparam int SYNC_W = 8;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] syn_in;
    logic              bclk_s, fsync_s, rxd_s, grant_s;
    logic [3:0]        chan_sel_s;
    logic              d_ev, s_ev, sync_hit, slot_ev;

    assign raw_in = {chan_sel, grant_in, rxd, fsync, bclk};
    assign {chan_sel_s, grant_s, rxd_s, fsync_s, bclk_s} = syn_in;

    tdm_aln_insync #(.W(SYNC_W)) u_insync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    tdm_aln_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_s    (bclk_s),
        .fsync_s   (fsync_s),
        .data_fall (cfg_data_edge),
        .sync_fall (cfg_sync_edge),
        .d_ev      (d_ev),
        .s_ev      (s_ev),
        .sync_hit  (sync_hit)
    );

    tdm_aln_fsm #(.FRAME_MAX(FRAME_MAX)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .d_ev          (d_ev),
        .sync_hit      (sync_hit),
        .rxd_s         (rxd_s),
        .cfg_delay     (cfg_delay),
        .cfg_frame_len (cfg_frame_len),
        .tx_frame      (tx_frame),
        .bit_idx       (bit_idx),
        .frame_act     (frame_act),
        .sof           (sof),
        .txd           (txd),
        .rx_frame      (rx_frame),
        .resync_err    (resync_err),
        .slot_ev       (slot_ev)
    );

    tdm_aln_grant u_grant (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sync  (cfg_grant_mode),
        .grant_en   (cfg_grant_en),
        .s_ev       (s_ev),
        .fsync_s    (fsync_s),
        .slot_ev    (slot_ev),
        .chan_sel_s (chan_sel_s),
        .rxd_s      (rxd_s),
        .grant_s    (grant_s),
        .grant      (grant)
    );

endmodule

// File: tb/tdm_sync_aligner_tb_top.sv
module tdm_sync_aligner_tb_top;

    localparam int FM = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    ph = 3'd0;
    logic          bclk;
    logic          fsync, rxd, grant_in;
    logic [3:0]    chan_sel;
    logic [1:0]    cfg_delay;
    logic          cfg_data_edge, cfg_sync_edge, cfg_grant_mode, cfg_grant_en;
    logic [IW:0]   cfg_frame_len;
    logic [FM-1:0] tx_frame;
    logic          txd, sof, frame_act, resync_err, grant;
    logic [FM-1:0] rx_frame;
    logic [IW-1:0] bit_idx;

    int n_chk = 0;
    int n_fail = 0;
    int err_seen = 0;

    always #10 clk = ~clk;
    always @(posedge clk) ph <= ph + 3'd1;
    assign bclk = ~ph[2];

    always @(posedge clk) if (rst_n && resync_err) err_seen++;

    tdm_sync_aligner #(.FRAME_MAX(FM)) dut_i (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .rxd(rxd),
        .chan_sel(chan_sel), .grant_in(grant_in), .cfg_delay(cfg_delay),
        .cfg_data_edge(cfg_data_edge), .cfg_sync_edge(cfg_sync_edge),
        .cfg_frame_len(cfg_frame_len), .cfg_grant_mode(cfg_grant_mode),
        .cfg_grant_en(cfg_grant_en), .tx_frame(tx_frame), .txd(txd),
        .rx_frame(rx_frame), .bit_idx(bit_idx), .sof(sof),
        .frame_act(frame_act), .resync_err(resync_err), .grant(grant)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic at_ph(int k);
        do @(negedge clk); while (ph != 3'(k));
    endtask

    task automatic idle_bits(int n);
        repeat (n) at_ph(6);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 frame_act", frame_act, 0);
        chk("R1 sof", sof, 0);
        chk("R1 txd", txd, 0);
        chk("R1 resync_err", resync_err, 0);
        chk("R1 grant", grant, 0);
        chk("R1 bit_idx", bit_idx, 0);
        chk("R1 rx_frame", rx_frame, 0);
    endtask

    // one aligned frame, checked bit by bit (R5 R6 R7 R8)
    task automatic run_frame(int dly, bit dedge, bit sedge, int len,
                             logic [FM-1:0] txp, logic [FM-1:0] rxp,
                             int mslot, logic [3:0] mcode, string tag);
        int off;
        logic [FM-1:0] mask;
        cfg_delay     = 2'(dly);
        cfg_data_edge = dedge;
        cfg_sync_edge = sedge;
        cfg_frame_len = 5'(len);
        tx_frame      = txp;
        off  = dly + ((sedge && !dedge) ? 1 : 0);
        mask = FM'((1 << len) - 1);
        at_ph(6);
        fsync = 1'b1;
        if (off == 0) begin
            rxd      = rxp[0];
            chan_sel = (mslot == 0) ? mcode : 4'h0;
        end
        at_ph(6);
        fsync = 1'b0;
        if (dedge) at_ph(2);
        for (int k = 0; k < off + len + 2; k++) begin
            automatic int  j   = k - off;
            automatic int  nj  = k - off + 1;
            automatic bit  act = (k >= off) && (k < off + len);
            chk({tag, " R5 frame_act"}, frame_act, act);
            chk({tag, " R6 sof"}, sof, (k == off));
            if (act) begin
                chk({tag, " R5 bit_idx"}, bit_idx, j);
                chk({tag, " R7 txd"}, txd, txp[j]);
            end else begin
                chk({tag, " R7 txd idle"}, txd, 0);
            end
            if (nj >= 0 && nj < len) begin
                rxd      = rxp[nj];
                chan_sel = (nj == mslot) ? mcode : 4'h0;
            end else begin
                rxd      = 1'b0;
                chan_sel = 4'h0;
            end
            at_ph(dedge ? 2 : 6);
        end
        chk({tag, " R8 rx_frame"}, int'(rx_frame & mask), int'(rxp & mask));
    endtask

    task automatic t_delays();
        for (int d = 0; d < 4; d++) begin
            run_frame(d, 1'b0, 1'b0, 4, 16'h000A, 16'h0005, -1, 4'h0, "R2");
        end
    endtask

    task automatic t_edges();
        run_frame(2, 1'b1, 1'b1, 6, 16'h0035, 16'h0029, -1, 4'h0, "R3 both falling");
        run_frame(0, 1'b0, 1'b1, 4, 16'h0009, 16'h0006, -1, 4'h0, "R4 sync falling");
        run_frame(1, 1'b1, 1'b0, 4, 16'h0006, 16'h0009, -1, 4'h0, "R3 R4 data falling");
    endtask

    task automatic t_mark_grant();
        cfg_grant_mode = 1'b0;
        run_frame(1, 1'b0, 1'b0, 8, 16'h00C5, 16'h003C, 3, 4'b0111, "R12 mark");
        chk("R12 marked bit one", grant, 1);
        run_frame(2, 1'b0, 1'b0, 8, 16'h005A, 16'h00C3, 3, 4'b0111, "R12 mark");
        chk("R12 marked bit zero", grant, 0);
        run_frame(0, 1'b0, 1'b0, 8, 16'h0081, 16'h0001, 0, 4'b0110, "R12 unmarked");
        chk("R12 unmarked ignored", grant, 0);
    endtask

    task automatic t_resync();
        int e0;
        e0 = err_seen;
        cfg_delay = 2'd1; cfg_data_edge = 1'b0; cfg_sync_edge = 1'b0;
        cfg_frame_len = 5'd8; tx_frame = 16'h00FF;
        at_ph(6); fsync = 1'b1;
        at_ph(6); fsync = 1'b0;
        at_ph(6); chk("R9 first sof", sof, 1);
        at_ph(6); chk("R9 bit_idx 1", bit_idx, 1);
        at_ph(6); chk("R9 bit_idx 2", bit_idx, 2);
        fsync = 1'b1;
        at_ph(6); fsync = 1'b0;
        chk("R9 restart delay frame_act", frame_act, 0);
        chk("R9 err pulses", err_seen - e0, 1);
        at_ph(6);
        chk("R9 restarted sof", sof, 1);
        chk("R9 restarted bit_idx", bit_idx, 0);
        chk("R9 restarted frame_act", frame_act, 1);
        idle_bits(10);
        chk("R9 single err pulse", err_seen - e0, 1);
    endtask

    task automatic t_back_to_back();
        int e0;
        e0 = err_seen;
        cfg_delay = 2'd0; cfg_data_edge = 1'b0; cfg_sync_edge = 1'b0;
        cfg_frame_len = 5'd4; tx_frame = 16'h0003;
        at_ph(6); fsync = 1'b1;
        at_ph(6); fsync = 1'b0;
        chk("R10 first sof", sof, 1);
        at_ph(6);
        at_ph(6);
        at_ph(6); chk("R10 last bit", bit_idx, 3);
        fsync = 1'b1;
        at_ph(6); fsync = 1'b0;
        chk("R10 new sof", sof, 1);
        chk("R10 new bit_idx", bit_idx, 0);
        chk("R10 frame_act", frame_act, 1);
        chk("R10 no err", err_seen - e0, 0);
        idle_bits(8);
        chk("R10 still no err", err_seen - e0, 0);
    endtask

    task automatic sync_grant(bit en, bit gin, int exp, string tag);
        cfg_grant_en = en;
        at_ph(6); fsync = 1'b1; grant_in = gin;
        at_ph(6); fsync = 1'b0; grant_in = 1'b0;
        chk(tag, grant, exp);
        idle_bits(6);
    endtask

    task automatic t_sync_grant();
        cfg_grant_mode = 1'b1;
        cfg_delay = 2'd0; cfg_data_edge = 1'b0; cfg_sync_edge = 1'b0;
        cfg_frame_len = 5'd4;
        sync_grant(1'b1, 1'b1, 1, "R11 enabled high");
        sync_grant(1'b0, 1'b1, 0, "R11 disabled");
        sync_grant(1'b1, 1'b1, 1, "R11 re-enabled");
        sync_grant(1'b1, 1'b0, 0, "R11 enabled low");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        fsync = 1'b0; rxd = 1'b0; grant_in = 1'b0; chan_sel = 4'h0;
        cfg_delay = 2'd0; cfg_data_edge = 1'b0; cfg_sync_edge = 1'b0;
        cfg_frame_len = 5'd4; cfg_grant_mode = 1'b0; cfg_grant_en = 1'b0;
        tx_frame = '0;
        t_reset();
        t_delays();
        t_edges();
        t_mark_grant();
        t_resync();
        t_back_to_back();
        t_sync_grant();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule